// File: doc/BRIEF.md
# Duty-Cycle Bit Demodulator

This block turns a pulse-width-modulated carrier back into a stream of bits, one bit per carrier cycle. The transmitter keeps its rising edges at a fixed rate, so those edges act as the bit clock. The data is carried by how long the pulse stays high. A short pulse of about one third of the period encodes a zero. A long pulse of about two thirds of the period encodes a one.

The carrier enters as a single-bit signal and passes through a two-flop synchroniser. A counter measures the number of system clocks between consecutive rising edges. Half of the last measured period becomes the sample point for the next cycle. The receiver declares lock once the measured period has held steady for several edges in a row. While locked, it emits the sampled level together with a one-clock valid strobe, once per carrier cycle.

Top module: `pwm_bit_demod`

## Requirements
- R1: After reset, `bit_out`, `bit_valid` and `locked` are all low.
- R2: A carrier cycle whose high time runs past the sample point (two-thirds duty) yields `bit_out` = 1 when its strobe fires. The sample point is half of the previous measured period, counted in clocks from the synchronised rising edge.
- R3: A carrier cycle whose high time ends before the sample point (one-third duty) yields `bit_out` = 0 when its strobe fires.
- R4: While locked, `bit_valid` pulses exactly once per carrier period, and each pulse lasts one clock.
- R5: While `locked` is low, `bit_valid` stays low.
- R6: Starting from an idle or reset state, `locked` rises at the 10th rising edge:
  - the 1st edge only marks a start;
  - the 2nd edge gives the first period;
  - edges 3 to 10 each find a period that agrees with the one before it.
  - `locked` is therefore high during the 10th carrier cycle and low during the 9th.
- R7: Two periods agree when they differ by no more than the earlier period shifted right by `TOL_SH` (default 3, i.e. 1/8). Alternating periods of 40 and 42 clocks keep lock.
- R8: A rising edge that ends a period outside that tolerance clears `locked` at once. After a 60-clock period follows 40-clock ones, the next cycle is unlocked and carries no strobe.
- R9: When the edge counter reaches `TIMEOUT` clocks with no rising edge, `locked` clears and the measured period is discarded.
- R10: Bits are recovered correctly for any steady period from 24 clocks up to well beyond 99 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_in | input | 1 | Modulated carrier, asynchronous to clk |
| bit_out | output | 1 | Most recently recovered bit |
| bit_valid | output | 1 | One-clock strobe marking a new bit |
| locked | output | 1 | High while synchronised to the carrier |

## Verification
The assertions assume that the carrier period exceeds a few clocks plus the synchroniser delay. This keeps the mid-period sample and its strobe inside the same cycle, and keeps the period below `TIMEOUT`. They also assume that each high time sits clearly on one side of the half-period point. The stimulus drives carrier transitions on falling clock edges only. It uses periods of 24 clocks or more, with high times of integer thirds, so every sample point has at least four clocks of margin from the falling edge. Out-of-tolerance steps, and stops in the carrier longer than the timeout, are produced on purpose and only in their own sequences. Each such sequence is followed by an idle gap, so every run starts from an unlocked state.

// File: rtl/pwm_bit_demod.sv
module pwm_bit_demod #(
  parameter int CNT_W   = 13,
  parameter int TIMEOUT = 6000,
  parameter int LOCK_N  = 8,
  parameter int TOL_SH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_in,
  output logic bit_out,
  output logic bit_valid,
  output logic locked
);
  localparam int AW = $clog2(LOCK_N + 1);
  localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT);
  localparam logic [AW-1:0] AGREE_LAST = AW'(LOCK_N - 1);

  logic [2:0]       sh;
  logic [CNT_W-1:0] cnt, per;
  logic             have_edge, have_per;
  logic [AW-1:0]    agree;

  wire              rise  = sh[1] & ~sh[2];
  wire              tmo   = (cnt == TMO);
  wire [CNT_W-1:0]  half  = per >> 1;
  wire [CNT_W-1:0]  diff  = (cnt > per) ? cnt - per : per - cnt;
  wire              match = (diff <= (per >> TOL_SH));
  wire              mid   = have_per && !rise && (cnt == half);

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], carrier_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      per       <= '0;
      have_edge <= 1'b0;
      have_per  <= 1'b0;
      agree     <= '0;
      locked    <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      if (rise) begin
        cnt       <= CNT_W'(1);
        have_edge <= 1'b1;
        if (have_edge) begin
          per      <= cnt;
          have_per <= 1'b1;
        end
        if (have_per && match) begin
          if (agree == AGREE_LAST) locked <= 1'b1;
          else                     agree  <= agree + 1'b1;
        end else begin
          agree  <= '0;
          locked <= 1'b0;
        end
      end else if (tmo) begin
        have_edge <= 1'b0;
        have_per  <= 1'b0;
        agree     <= '0;
        locked    <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (mid) begin
        bit_out   <= sh[1];
        bit_valid <= locked;
      end
    end
  end
endmodule

// File: rtl/pwm_bit_demod_chk.sv
module pwm_bit_demod_chk #(
  parameter int CNT_W   = 13,
  parameter int TIMEOUT = 6000,
  parameter int TOL_SH  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per,
  input logic             bit_valid,
  input logic             locked
);
  wire [CNT_W-1:0] dev = (cnt > per) ? cnt - per : per - cnt;

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
  p_strobe_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> locked);
  p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rise));
  p_wide_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && dev > (per >> TOL_SH)) |=> !locked);
  p_timeout_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(TIMEOUT) && !rise) |=> !locked);
  p_mid_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> ($past(cnt) == ($past(per) >> 1)));
endmodule

bind pwm_bit_demod pwm_bit_demod_chk #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .TOL_SH(TOL_SH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .cnt(cnt), .per(per),
  .bit_valid(bit_valid), .locked(locked)
);

// File: tb/sim_pwm_bit_demod.sv
module sim_pwm_bit_demod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier_in = 1'b0;
  logic bit_out, bit_valid, locked;

  int checks = 0;
  int errors = 0;
  int nstb = 0;
  logic exp_bit = 1'b0;
  logic idle = 1'b1;
  logic prev_v = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  pwm_bit_demod u0 (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in),
    .bit_out(bit_out), .bit_valid(bit_valid), .locked(locked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        nstb++;
        if (idle) chk(1'b0, "R5 strobe during idle", 1, 0);
        else chk(bit_out == exp_bit, exp_bit ? "R2 bit one" : "R3 bit zero", int'(bit_out), int'(exp_bit));
      end
      if (bit_valid && prev_v) chk(1'b0, "R4 strobe width", 2, 1);
      prev_v = bit_valid;
    end
  end

  task automatic send_period(input int p, input logic b);
    int hi;
    hi = b ? (2 * p) / 3 : p / 3;
    exp_bit = b;
    nstb = 0;
    carrier_in = 1'b1;
    repeat (hi) @(negedge clk);
    carrier_in = 1'b0;
    repeat (p - hi) @(negedge clk);
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic go_idle();
    idle = 1'b1;
    nstb = 0;
    carrier_in = 1'b0;
    repeat (6100) @(negedge clk);
    chk(locked == 1'b0, "R9 lock after timeout", int'(locked), 0);
    chk(nstb == 0, "R9 no strobe while idle", nstb, 0);
  endtask

  task automatic run_seq(input int pa, input int pb, input int n, input string tag);
    idle = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_period((i % 2) ? pb : pa, next_bit());
      chk(locked == (i >= 9), {tag, " R6 lock timing"}, int'(locked), int'(i >= 9));
      chk(nstb == ((i >= 9) ? 1 : 0), {tag, " R4/R5 strobe count"}, nstb, (i >= 9) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bit_out == 1'b0 && bit_valid == 1'b0 && locked == 1'b0, "R1 reset state",
        int'({bit_out, bit_valid, locked}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(locked == 1'b0, "R1 unlocked out of reset", int'(locked), 0);

    run_seq(30, 30, 40, "R2 R3 base");
    go_idle();

    run_seq(40, 42, 30, "R7 jitter");
    idle = 1'b0;
    send_period(60, 1'b1);
    chk(nstb == 1, "R8 strobe in long period", nstb, 1);
    send_period(40, 1'b0);
    chk(locked == 1'b0, "R8 lock dropped", int'(locked), 0);
    chk(nstb == 0, "R8 no strobe after drop", nstb, 0);
    go_idle();

    foreach (sweep_p[k]) begin
      run_seq(sweep_p[k], sweep_p[k], 14, "R10 sweep");
      go_idle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int sweep_p[6] = '{24, 33, 48, 66, 99, 150};

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule